// File: doc/BRIEF.md
# Two-Channel Request/Acknowledge DMA Slave

This block is the device side of an external DMA port. An outside DMA controller moves words between its own memory and four internal stream FIFOs by a request/acknowledge handshake. The block has two channels that run independently. Each channel has a request output `dreq[c]` and an acknowledge input `dack[c]`. Each channel also has configuration that names the FIFO it serves, the transfer direction, and whether it asks for one word at a time or for a whole burst.

The acknowledge inputs are asynchronous. Each passes through a two-flop synchronizer, and a word moves on the rising edge of the synchronized acknowledge. A write channel pushes the controller's word into its FIFO. A read channel pops the head of its FIFO and presents that word on its own `dma_rdata` lane. The port carries full 32-bit words when `bus_wide` is high. When `bus_wide` is low it carries only the low half: the upper half is dropped on writes and returned as zero on reads.

If both channels name the same FIFO, channel 1 is shut off and reports a configuration error. An acknowledge that would overflow a full FIFO or underflow an empty one is refused, and a sticky per-channel error flag is raised.

Top module: `dma_req_slave`

## Requirements
- R1: After reset, `dreq`, `fifo_push`, `fifo_pop`, `cfg_err` and `xfer_err` are all zero.
- R2: In single mode (`ch_burst[c]`=0), an enabled channel raises `dreq[c]` only when at least one word can move. A write channel (`ch_dir[c]`=1) needs `fifo_count` below `DEPTH`; a read channel (`ch_dir[c]`=0) needs `fifo_count` above zero. The channel drops `dreq[c]` when it accepts an acknowledge, and raises it again only after `dack[c]` has been released.
- R3: In burst mode (`ch_burst[c]`=1), `dreq[c]` rises only when `BURST_LEN` words can move. It stays high through the first `BURST_LEN`-1 accepted acknowledges and falls on the last one.
- R4: The FIFO for channel c is selected by `ch_sel[2c+1:2c]`, with values 0 to 3 meaning FIFO 0 to 3. Push and pop strobes appear only on the selected FIFO.
- R5: On an accepted write, the FIFO receives a one-cycle `fifo_push` carrying `dma_wdata` lane c on its `fifo_wdata` lane. On an accepted read, the FIFO receives a one-cycle `fifo_pop`, and `dma_rdata` lane c takes the value that was on that FIFO's `fifo_rdata` lane.
- R6: With `bus_wide`=0, bits 31:16 of every pushed word and of every `dma_rdata` result are zero. With `bus_wide`=1, all 32 bits pass.
- R7: If both channels are enabled on the same FIFO, `cfg_err[1]` is set, channel 1 never requests, and its acknowledges move nothing. Channel 0 is unaffected. When the clash ends, channel 1 resumes.
- R8: An acknowledge to a write channel whose FIFO is full, or to a read channel whose FIFO is empty, moves nothing and sets `xfer_err[c]`. The flag holds until the channel is disabled.
- R9: The two channels transfer at the same time without affecting each other.
- R10: A word moves on the third rising clock edge after `dack[c]` rises, counting the edge that first samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wide | input | 1 | 1: 32-bit words, 0: low 16 bits only |
| ch_en | input | 2 | Per-channel enable |
| ch_dir | input | 2 | Per-channel direction, 1 = into FIFO, 0 = out of FIFO |
| ch_burst | input | 2 | Per-channel mode, 1 = burst, 0 = single |
| ch_sel | input | 4 | Per-channel FIFO select, 2 bits each |
| dack | input | 2 | Asynchronous acknowledge per channel |
| dma_wdata | input | 64 | Write word per channel (32 bits each) |
| dma_rdata | output | 64 | Read word per channel (32 bits each) |
| dreq | output | 2 | Request per channel |
| fifo_count | input | 20 | Fill level of each FIFO (5 bits each) |
| fifo_rdata | input | 128 | Head word of each FIFO (32 bits each) |
| fifo_push | output | 4 | Push strobe per FIFO |
| fifo_pop | output | 4 | Pop strobe per FIFO |
| fifo_wdata | output | 128 | Push data per FIFO (32 bits each) |
| cfg_err | output | 2 | Channel disabled by a FIFO clash (bit 1 only) |
| xfer_err | output | 2 | Sticky overflow/underflow flag per channel |

## Verification
Results arrive at three different delays, and each check waits for its own delay:

- **Acknowledge effects.** Push, pop, `dma_rdata` and `xfer_err` change on the third edge after `dack` rises. The bench drives `dack` on a falling edge and reads these results three falling edges later, at which point the strobes are visible.
- **Configuration changes.** A change of configuration passes through the clash register before the channel responds, so `dreq` and `cfg_err` are read three cycles after it.
- **Release of acknowledge.** The release needs two synchronizer stages, a state change and a request register before `dreq` can rise again. The bench waits five cycles after dropping `dack` before it reads `dreq`.

The bench's FIFO model counts every push and pop, so refused acknowledges are checked through unchanged counts at the ports.

// File: rtl/dma_slave_pkg.sv
package dma_slave_pkg;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_REQ  = 2'd1,
    CH_REL  = 2'd2
  } ch_state_e;

endpackage

// File: rtl/dma_ack_sync.sv
module dma_ack_sync #(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] dack_async,
  output logic [NCH-1:0] ack_lvl,
  output logic [NCH-1:0] ack_rise
);

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      logic meta_q, sync_q, prev_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          meta_q <= 1'b0;
          sync_q <= 1'b0;
          prev_q <= 1'b0;
        end else begin
          meta_q <= dack_async[c];
          sync_q <= meta_q;
          prev_q <= sync_q;
        end
      end

      assign ack_lvl[c]  = sync_q;
      assign ack_rise[c] = sync_q & ~prev_q;
    end
  endgenerate

endmodule

// File: rtl/dma_cfg_guard.sv
module dma_cfg_guard #(
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [1:0]      en_raw,
  input  logic [2*SELW-1:0] sel,
  output logic [1:0]      en_eff,
  output logic [1:0]      cfg_err
);

  logic clash;

  assign clash = en_raw[0] & en_raw[1] & (sel[SELW-1:0] == sel[2*SELW-1:SELW]);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_eff  <= 2'b00;
      cfg_err <= 2'b00;
    end else begin
      en_eff  <= {en_raw[1] & ~clash, en_raw[0]};
      cfg_err <= {clash, 1'b0};
    end
  end

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_slave_pkg::*;
#(
  parameter int DW        = 32,
  parameter int DEPTH     = 16,
  parameter int BURST_LEN = 8,
  parameter int CW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          dir,
  input  logic          burst,
  input  logic          wide,
  input  logic          ack_lvl,
  input  logic          ack_rise,
  input  logic [CW-1:0] sel_count,
  input  logic [DW-1:0] sel_rdata,
  input  logic [DW-1:0] wdata_in,
  output logic          dreq,
  output logic          push,
  output logic          pop,
  output logic [DW-1:0] wdata_out,
  output logic [DW-1:0] rdata_out,
  output logic          xfer_err
);

  localparam int HALF = DW / 2;
  localparam int BCW  = $clog2(BURST_LEN + 1);

  ch_state_e      state;
  logic [BCW-1:0] beat;
  logic           ready;
  logic           blocked;
  int             need;
  int             room;

  function automatic logic [DW-1:0] fit(input logic [DW-1:0] d, input logic w);
    fit = w ? d : {{(DW-HALF){1'b0}}, d[HALF-1:0]};
  endfunction

  always_comb begin
    need    = burst ? BURST_LEN : 1;
    room    = dir ? (DEPTH - int'(sel_count)) : int'(sel_count);
    ready   = (room >= need);
    blocked = dir ? (int'(sel_count) >= DEPTH) : (sel_count == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      state    <= CH_IDLE;
      dreq     <= 1'b0;
      beat     <= '0;
      push     <= 1'b0;
      pop      <= 1'b0;
      xfer_err <= 1'b0;
    end else begin
      push <= 1'b0;
      pop  <= 1'b0;
      if (ack_rise) begin
        if (blocked) begin
          xfer_err <= 1'b1;
        end else begin
          push <= dir;
          pop  <= ~dir;
          if (state == CH_REQ) begin
            if (!burst || beat == BCW'(BURST_LEN - 1)) begin
              dreq  <= 1'b0;
              state <= CH_REL;
              beat  <= '0;
            end else begin
              beat <= beat + 1'b1;
            end
          end
        end
      end else begin
        case (state)
          CH_IDLE: if (!ack_lvl && ready) begin
            dreq  <= 1'b1;
            state <= CH_REQ;
          end
          CH_REL: if (!ack_lvl) state <= CH_IDLE;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wdata_out <= '0;
      rdata_out <= '0;
    end else if (en && ack_rise && !blocked) begin
      if (dir) wdata_out <= fit(wdata_in, wide);
      else     rdata_out <= fit(sel_rdata, wide);
    end
  end

endmodule

// File: rtl/dma_fifo_route.sv
module dma_fifo_route #(
  parameter int DW    = 32,
  parameter int NFIFO = 4,
  parameter int NCH   = 2,
  parameter int SELW  = 2
) (
  input  logic [NCH*SELW-1:0]  sel,
  input  logic [NCH-1:0]       ch_push,
  input  logic [NCH-1:0]       ch_pop,
  input  logic [NCH*DW-1:0]    ch_wdata,
  output logic [NFIFO-1:0]     fifo_push,
  output logic [NFIFO-1:0]     fifo_pop,
  output logic [NFIFO*DW-1:0]  fifo_wdata
);

  always_comb begin
    fifo_push  = '0;
    fifo_pop   = '0;
    fifo_wdata = '0;
    for (int f = 0; f < NFIFO; f++) begin
      for (int c = NCH - 1; c >= 0; c--) begin
        if (int'(sel[c*SELW +: SELW]) == f) begin
          if (ch_push[c]) begin
            fifo_push[f]             = 1'b1;
            fifo_wdata[f*DW +: DW]   = ch_wdata[c*DW +: DW];
          end
          if (ch_pop[c]) fifo_pop[f] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dma_req_slave.sv
module dma_req_slave #(
  parameter int DW        = 32,
  parameter int DEPTH     = 16,
  parameter int BURST_LEN = 8,
  parameter int NFIFO     = 4,
  parameter int CW        = $clog2(DEPTH + 1),
  parameter int SELW      = $clog2(NFIFO)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wide,
  input  logic [1:0]           ch_en,
  input  logic [1:0]           ch_dir,
  input  logic [1:0]           ch_burst,
  input  logic [2*SELW-1:0]    ch_sel,
  input  logic [1:0]           dack,
  input  logic [2*DW-1:0]      dma_wdata,
  output logic [2*DW-1:0]      dma_rdata,
  output logic [1:0]           dreq,
  input  logic [NFIFO*CW-1:0]  fifo_count,
  input  logic [NFIFO*DW-1:0]  fifo_rdata,
  output logic [NFIFO-1:0]     fifo_push,
  output logic [NFIFO-1:0]     fifo_pop,
  output logic [NFIFO*DW-1:0]  fifo_wdata,
  output logic [1:0]           cfg_err,
  output logic [1:0]           xfer_err
);

  localparam int NCH = 2;

  logic [NCH-1:0]    ack_lvl, ack_rise, en_eff, ch_push, ch_pop;
  logic [NCH*DW-1:0] ch_wdata;

  dma_ack_sync #(.NCH(NCH)) u_sync (
    .clk(clk), .rst(rst), .dack_async(dack),
    .ack_lvl(ack_lvl), .ack_rise(ack_rise)
  );

  dma_cfg_guard #(.SELW(SELW)) u_guard (
    .clk(clk), .rst(rst), .en_raw(ch_en), .sel(ch_sel),
    .en_eff(en_eff), .cfg_err(cfg_err)
  );

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_chan
      logic [SELW-1:0] s;
      assign s = ch_sel[c*SELW +: SELW];

      dma_chan_ctrl #(.DW(DW), .DEPTH(DEPTH), .BURST_LEN(BURST_LEN), .CW(CW)) u_ctrl (
        .clk(clk), .rst(rst), .en(en_eff[c]), .dir(ch_dir[c]),
        .burst(ch_burst[c]), .wide(bus_wide),
        .ack_lvl(ack_lvl[c]), .ack_rise(ack_rise[c]),
        .sel_count(fifo_count[s*CW +: CW]),
        .sel_rdata(fifo_rdata[s*DW +: DW]),
        .wdata_in(dma_wdata[c*DW +: DW]),
        .dreq(dreq[c]), .push(ch_push[c]), .pop(ch_pop[c]),
        .wdata_out(ch_wdata[c*DW +: DW]),
        .rdata_out(dma_rdata[c*DW +: DW]),
        .xfer_err(xfer_err[c])
      );
    end
  endgenerate

  dma_fifo_route #(.DW(DW), .NFIFO(NFIFO), .NCH(NCH), .SELW(SELW)) u_route (
    .sel(ch_sel), .ch_push(ch_push), .ch_pop(ch_pop), .ch_wdata(ch_wdata),
    .fifo_push(fifo_push), .fifo_pop(fifo_pop), .fifo_wdata(fifo_wdata)
  );

endmodule

// File: rtl/dma_req_slave_chk.sv
module dma_req_slave_chk #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int NFIFO = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_wide,
  input logic [1:0]          dreq,
  input logic [1:0]          cfg_err,
  input logic [NFIFO*CW-1:0] fifo_count,
  input logic [NFIFO-1:0]    fifo_push,
  input logic [NFIFO-1:0]    fifo_pop,
  input logic [NFIFO*DW-1:0] fifo_wdata
);

  localparam int HALF = DW / 2;

  genvar f;
  generate
    for (f = 0; f < NFIFO; f++) begin : g_f
      // R8
      no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_push[f] |-> (int'(fifo_count[f*CW +: CW]) < DEPTH));
      // R8
      no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_pop[f] |-> (fifo_count[f*CW +: CW] != '0));
      // R6
      narrow_push_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_push[f] && !$past(bus_wide)) |-> (fifo_wdata[f*DW+HALF +: (DW-HALF)] == '0));
    end
  endgenerate

  // R4
  push_pop_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_push & fifo_pop) == '0);

  // R7
  clash_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_err[1] && $past(cfg_err[1])) |-> !dreq[1]);

  // R7
  ch0_no_clash_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_err[0]);

endmodule

bind dma_req_slave dma_req_slave_chk #(
  .DW(DW), .DEPTH(DEPTH), .NFIFO(NFIFO), .CW(CW)
) u_chk (
  .clk(clk), .rst(rst), .bus_wide(bus_wide), .dreq(dreq), .cfg_err(cfg_err),
  .fifo_count(fifo_count), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
  .fifo_wdata(fifo_wdata)
);

// File: tb/dma_req_slave_bench.sv
module dma_req_slave_bench;

  localparam int DW = 32, DEPTH = 16, BL = 8, NF = 4, CW = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wide = 1'b1;
  logic [1:0] ch_en = 0, ch_dir = 0, ch_burst = 0, dack = 0;
  logic [3:0] ch_sel = 0;
  logic [2*DW-1:0] dma_wdata = 0;
  logic [2*DW-1:0] dma_rdata;
  logic [1:0] dreq, cfg_err, xfer_err;
  logic [NF*CW-1:0] fifo_count;
  logic [NF*DW-1:0] fifo_rdata, fifo_wdata;
  logic [NF-1:0] fifo_push, fifo_pop;

  int cnt [NF];
  int npush [NF];
  int npop [NF];
  logic [DW-1:0] lastw [NF];
  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_req_slave u_dma_req_slave (
    .clk(clk), .rst(rst), .bus_wide(bus_wide), .ch_en(ch_en), .ch_dir(ch_dir),
    .ch_burst(ch_burst), .ch_sel(ch_sel), .dack(dack), .dma_wdata(dma_wdata),
    .dma_rdata(dma_rdata), .dreq(dreq), .fifo_count(fifo_count),
    .fifo_rdata(fifo_rdata), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
    .fifo_wdata(fifo_wdata), .cfg_err(cfg_err), .xfer_err(xfer_err)
  );

  function automatic logic [DW-1:0] head(input int f, input int n);
    head = 32'hC0DE_0000 | DW'(f << 8) | DW'(n);
  endfunction

  genvar g;
  generate
    for (g = 0; g < NF; g++) begin : g_model
      assign fifo_count[g*CW +: CW] = CW'(cnt[g]);
      assign fifo_rdata[g*DW +: DW] = head(g, cnt[g]);
      always @(posedge clk) begin
        if (fifo_push[g]) begin
          cnt[g]   <= cnt[g] + 1;
          npush[g] <= npush[g] + 1;
          lastw[g] <= fifo_wdata[g*DW +: DW];
        end
        if (fifo_pop[g]) begin
          cnt[g]  <= cnt[g] - 1;
          npop[g] <= npop[g] + 1;
        end
      end
    end
  endgenerate

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_ch(input int c, input bit en, input bit dir, input bit bst, input int sel);
    ch_en[c] = en; ch_dir[c] = dir; ch_burst[c] = bst;
    ch_sel[c*2 +: 2] = 2'(sel);
  endtask

  task automatic clear_all();
    ch_en = 0; dack = 0; cyc(3);
    for (int f = 0; f < NF; f++) begin cnt[f] = 0; npush[f] = 0; npop[f] = 0; end
    cyc(1);
  endtask

  // R10: raise dack, move is visible three falling edges later; then release.
  task automatic ack_on(input int c);
    dack[c] = 1'b1; cyc(3);
  endtask
  task automatic ack_off(input int c);
    dack[c] = 1'b0; cyc(5);
  endtask

  task automatic t_reset();
    check(dreq == 0 && fifo_push == 0 && fifo_pop == 0, "R1 outputs", {dreq, fifo_push, fifo_pop}, 0);
    check(cfg_err == 0 && xfer_err == 0, "R1 flags", {cfg_err, xfer_err}, 0);
  endtask

  task automatic t_single_write();
    clear_all();
    bus_wide = 1;
    set_ch(0, 1, 1, 0, 2); cyc(3);
    check(dreq[0] == 1, "R2 dreq on room", dreq[0], 1);
    dma_wdata[31:0] = 32'h1234_5678;
    ack_on(0);
    check(fifo_push == 4'b0100, "R4 push on fifo2 (R10 timing)", fifo_push, 4'b0100);
    check(fifo_wdata[2*DW +: DW] == 32'h1234_5678, "R5 push data", fifo_wdata[2*DW +: DW], 32'h1234_5678);
    check(dreq[0] == 0, "R2 dreq drops on ack", dreq[0], 0);
    cyc(4);
    check(dreq[0] == 0 && npush[2] == 1, "R2 no re-request while held", {dreq[0], 8'(npush[2])}, 1);
    ack_off(0);
    check(dreq[0] == 1, "R2 re-request after release", dreq[0], 1);
  endtask

  task automatic t_single_read();
    clear_all();
    cnt[1] = 3;
    set_ch(1, 1, 0, 0, 1); cyc(3);
    check(dreq[1] == 1, "R2 read dreq", dreq[1], 1);
    ack_on(1);
    check(fifo_pop == 4'b0010, "R4 pop on fifo1", fifo_pop, 4'b0010);
    check(dma_rdata[DW +: DW] == head(1, 3), "R5 read data", dma_rdata[DW +: DW], head(1, 3));
    ack_off(1);
    check(cnt[1] == 2, "R5 one pop", cnt[1], 2);
  endtask

  task automatic t_narrow();
    clear_all();
    bus_wide = 0;
    cnt[3] = 1;
    set_ch(0, 1, 1, 0, 0);
    set_ch(1, 1, 0, 0, 3); cyc(3);
    dma_wdata[31:0] = 32'hDEAD_BEEF;
    ack_on(0); ack_off(0);
    check(lastw[0] == 32'h0000_BEEF, "R6 narrow write", lastw[0], 32'h0000_BEEF);
    ack_on(1);
    check(dma_rdata[DW +: DW] == (head(3, 1) & 32'hFFFF), "R6 narrow read",
          dma_rdata[DW +: DW], head(3, 1) & 32'hFFFF);
    ack_off(1);
    bus_wide = 1;
  endtask

  task automatic t_burst();
    clear_all();
    cnt[0] = BL - 3;
    set_ch(0, 1, 0, 1, 0); cyc(3);
    check(dreq[0] == 0, "R3 no burst request below length", dreq[0], 0);
    cnt[0] = BL; cyc(3);
    check(dreq[0] == 1, "R3 burst request at length", dreq[0], 1);
    for (int i = 0; i < BL - 1; i++) begin
      ack_on(0); ack_off(0);
    end
    check(dreq[0] == 1 && npop[0] == BL - 1, "R3 holds mid burst", {dreq[0], 8'(npop[0])}, {1'b1, 8'(BL - 1)});
    ack_on(0);
    check(dreq[0] == 0, "R3 drops on last beat", dreq[0], 0);
    ack_off(0);
    check(npop[0] == BL && dreq[0] == 0, "R3 burst done, fifo empty", npop[0], BL);
    set_ch(1, 1, 1, 1, 2);
    cnt[2] = DEPTH - BL + 1; cyc(3);
    check(dreq[1] == 0, "R3 write burst needs full room", dreq[1], 0);
    cnt[2] = DEPTH - BL; cyc(3);
    check(dreq[1] == 1, "R3 write burst room ok", dreq[1], 1);
  endtask

  task automatic t_clash();
    clear_all();
    cnt[3] = 0;
    set_ch(0, 1, 0, 0, 3);
    set_ch(1, 1, 1, 0, 3); cyc(3);
    check(cfg_err == 2'b10, "R7 clash flagged", cfg_err, 2'b10);
    check(dreq[1] == 0, "R7 channel 1 silent", dreq[1], 0);
    ack_on(1); ack_off(1);
    check(npush[3] == 0, "R7 channel 1 ack ignored", npush[3], 0);
    cnt[3] = 2; cyc(3);
    check(dreq[0] == 1, "R7 channel 0 unaffected", dreq[0], 1);
    ch_en[0] = 0; cyc(3);
    check(cfg_err == 0 && dreq[1] == 1, "R7 clash cleared", {cfg_err, dreq[1]}, 1);
  endtask

  task automatic t_overflow();
    clear_all();
    cnt[1] = DEPTH;
    set_ch(0, 1, 1, 0, 1); cyc(3);
    check(dreq[0] == 0, "R2 no request when full", dreq[0], 0);
    ack_on(0); ack_off(0);
    check(npush[1] == 0 && xfer_err[0] == 1, "R8 overflow refused", {8'(npush[1]), xfer_err[0]}, 1);
    cyc(3);
    check(xfer_err[0] == 1, "R8 flag sticky", xfer_err[0], 1);
    ch_en[0] = 0; cyc(2);
    check(xfer_err[0] == 0, "R8 flag clears on disable", xfer_err[0], 0);
    set_ch(1, 1, 0, 0, 2); cyc(3);
    ack_on(1); ack_off(1);
    check(npop[2] == 0 && xfer_err[1] == 1, "R8 underflow refused", {8'(npop[2]), xfer_err[1]}, 1);
  endtask

  task automatic t_parallel();
    clear_all();
    cnt[1] = 4;
    set_ch(0, 1, 1, 0, 0);
    set_ch(1, 1, 0, 0, 1); cyc(3);
    dma_wdata = {32'h0, 32'hA0A0_0001};
    dack = 2'b11; cyc(3);
    check(fifo_push == 4'b0001 && fifo_pop == 4'b0010, "R9 both move", {fifo_push, fifo_pop}, 8'h12);
    check(dma_rdata[DW +: DW] == head(1, 4), "R9 read lane", dma_rdata[DW +: DW], head(1, 4));
    dack = 2'b00; cyc(5);
    check(lastw[0] == 32'hA0A0_0001 && cnt[1] == 3, "R9 results", lastw[0], 32'hA0A0_0001);
  endtask

  initial begin
    for (int f = 0; f < NF; f++) begin cnt[f] = 0; npush[f] = 0; npop[f] = 0; lastw[f] = 0; end
    cyc(4); rst = 1'b0; cyc(2);
    t_reset();
    t_single_write();
    t_single_read();
    t_narrow();
    t_burst();
    t_clash();
    t_overflow();
    t_parallel();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule